// File: doc/BRIEF.md
# Flow-Through Burst SRAM

This block is a small synchronous static memory that serves four-word bursts. A start address is captured on a clock edge by one of two address strobes. The two low address bits then come from an internal 2-bit beat counter, and the upper bits stay frozen in the address register. The counter steps on each edge where the advance input is low. A static order pin chooses the beat order: linear (wrap-around increment) or interleaved (XOR with the beat count). Read data is not registered on its way out. The word at the address in effect is presented combinationally during the same cycle in which that address is held. The output is gated by output enable.

Each word is made of 9-bit byte lanes, each lane carrying eight data bits and one parity bit. A write can cover all lanes through global write, or only chosen lanes through byte-write enable and per-lane selects. The write always targets the address in effect at that edge. Chip enable and two chip selects (one active high, one active low) qualify every strobe, and an unqualified strobe deselects the block after one edge. A sleep input freezes the block.

The read side is a one-way stream: `rd_valid` qualifies `rdata`, and there is no ready input. The memory cannot stall, so a consumer that needs a beat must take it in the cycle where it is shown. The host holds `adv_n` high to keep a beat on the output for more cycles.

Top module: `fts_burst_ram`

## Requirements
- R1: A strobe loads `addr_i` as the burst start (beat 0) when `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0. `cpu_stb_n` is ignored while `ce_n`=1. When both strobes are low, `cpu_stb_n` wins, and an edge that loads through `cpu_stb_n` writes nothing, whatever the write controls are.
- R2: In the cycle after a loading edge, `rdata` equals the word at the loaded address and `rd_valid`=1, provided `oe_n`=0. While `oe_n`=1, `rd_valid`=0 and `rdata`=0.
- R3: The beat counter steps only on edges with `adv_n`=0. With `adv_n`=1 the same word stays on `rdata`.
- R4: With `order_il`=0 the low two address bits are start+k modulo 4 for beat k. After the fourth beat the counter wraps to the start word, and the upper address bits never change during a burst.
- R5: With `order_il`=1 the low two address bits are start XOR k for beat k (k = 0, 1, 2, 3).
- R6: `gw_n`=0 writes all lanes of `wdata`, regardless of `bwe_n` and `bw_n`.
- R7: With `gw_n`=1 and `bwe_n`=0, lane i (bits 9i+8..9i) is written only when `bw_n[i]`=0. With `gw_n`=1 and `bwe_n`=1, nothing is written.
- R8: A write targets the address in effect at that edge: on an edge loading through `ctl_stb_n` this is `addr_i`, and on an edge with no accepted strobe it is the current beat address. The written word is visible on `rdata` in the next cycle when the counter holds.
- R9: An accepted strobe (`ctl_stb_n`=0, or `cpu_stb_n`=0 with `ce_n`=0) while `ce_n`=1, `cs_hi`=0 or `cs_lo_n`=1 deselects the block. From the next cycle `rd_valid`=0, and advancing does not bring it back.
- R10: While `sleep`=1, `rd_valid`=0 and `rdata`=0, and edges change neither the burst state nor the memory. After `sleep` falls the burst resumes where it stood.
- R11: After reset the block is deselected (`rd_valid`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW (8) | Burst start address |
| cpu_stb_n | input | 1 | Processor-side address strobe, active low, higher priority |
| ctl_stb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NB (2) | Per-lane write selects, active low |
| sleep | input | 1 | Power-down freeze, active high |
| wdata | input | NB*9 (18) | Write data |
| rdata | output | NB*9 (18) | Flow-through read data, zero when not valid |
| rd_valid | output | 1 | Read data qualifier |

## Verification
Two functions can land on the same edge: a lane write and a counter step. With `adv_n` low during byte writes, each write must land on the beat that was current, while the counter moves to the next beat. The burst is then re-read in order and each word is compared lane by lane. The second collision is between the two strobes together with an asserted global write. The word at the loaded address must come back unchanged, which shows that the processor strobe won and that its load cycle wrote nothing.

// File: rtl/fts_pkg.sv
package fts_pkg;
  // Low two address bits for beat k of a burst starting at `start`.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] k,
                                          input logic       il);
    logic [1:0] r;
    if (il) r = start ^ k;
    else    r = start + k;
    return r;
  endfunction
endpackage

// File: rtl/fts_seq.sv
module fts_seq import fts_pkg::*; #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          cpu_stb_n,
  input  logic          ctl_stb_n,
  input  logic          adv_n,
  input  logic          order_il,
  input  logic          ce_n,
  input  logic          cs_hi,
  input  logic          cs_lo_n,
  input  logic          sleep,
  output logic [AW-1:0] cur_addr,
  output logic          active,
  output logic          cpu_load,
  output logic          ctl_load,
  output logic          burst_cyc
);
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;
  logic          active_q;
  logic          sel, cpu_take, ctl_take, desel;

  assign sel       = !ce_n && cs_hi && !cs_lo_n;
  assign cpu_take  = !sleep && !cpu_stb_n && !ce_n;
  assign ctl_take  = !sleep && !ctl_stb_n && !cpu_take;
  assign cpu_load  = cpu_take && sel;
  assign ctl_load  = ctl_take && sel;
  assign desel     = (cpu_take || ctl_take) && !sel;
  assign burst_cyc = !sleep && active_q && !cpu_take && !ctl_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
    end else if (desel) begin
      active_q <= 1'b0;
    end else if (cpu_load || ctl_load) begin
      active_q <= 1'b1;
      base_q   <= addr_i;
      beat_q   <= '0;
    end else if (burst_cyc && !adv_n) begin
      beat_q   <= beat_q + 2'd1;
    end
  end

  assign cur_addr = {base_q[AW-1:2], beat_low(base_q[1:0], beat_q, order_il)};
  assign active   = active_q;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_cyc && adv_n) |=> $stable(beat_q));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_cyc && !adv_n && beat_q == 2'd3) |=> (beat_q == 2'd0));
  assert_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_load || ctl_load) |=> $stable(base_q));
  assert_desel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !active_q);
  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(active_q) && $stable(beat_q)));
endmodule

// File: rtl/fts_lanes.sv
module fts_lanes #(
  parameter int NB = 2
) (
  input  logic          go,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  output logic [NB-1:0] we
);
  always_comb begin
    we = '0;
    if (go) begin
      if (!gw_n)       we = '1;
      else if (!bwe_n) we = ~bw_n;
    end
  end
endmodule

// File: rtl/fts_array.sv
module fts_array #(
  parameter int AW = 8,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic [NB-1:0]    we,
  input  logic [AW-1:0]    waddr,
  input  logic [NB*BW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*BW +: BW];
    end
    assign rdata[g*BW +: BW] = mem[raddr];
  end
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram #(
  parameter int AW = 8,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_i,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             adv_n,
  input  logic             order_il,
  input  logic             ce_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             oe_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [NB-1:0]    bw_n,
  input  logic             sleep,
  input  logic [NB*BW-1:0] wdata,
  output logic [NB*BW-1:0] rdata,
  output logic             rd_valid
);
  localparam int DW = NB * BW;

  logic [AW-1:0] cur_addr, waddr;
  logic          active, cpu_load, ctl_load, burst_cyc, wr_go;
  logic [NB-1:0] lane_we;
  logic [DW-1:0] arr_q;

  fts_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
    .order_il(order_il), .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .sleep(sleep), .cur_addr(cur_addr), .active(active),
    .cpu_load(cpu_load), .ctl_load(ctl_load), .burst_cyc(burst_cyc)
  );

  assign wr_go = ctl_load || burst_cyc;
  assign waddr = ctl_load ? addr_i : cur_addr;

  fts_lanes #(.NB(NB)) u_lanes (
    .go(wr_go), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .we(lane_we)
  );

  fts_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
    .clk(clk), .we(lane_we), .waddr(waddr), .wdata(wdata),
    .raddr(cur_addr), .rdata(arr_q)
  );

  assign rd_valid = active && !oe_n && !sleep;
  assign rdata    = rd_valid ? arr_q : '0;

  assert_cpu_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_load |-> (lane_we == '0));
  assert_gw_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !gw_n) |-> (&lane_we));
  assert_sleep_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0));
  assert_idle_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !ctl_load |-> (lane_we == '0));
endmodule

// File: tb/tb_fts_burst_ram.sv
module tb_fts_burst_ram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        cpu_stb_n, ctl_stb_n, adv_n, order_il, ce_n, cs_hi, cs_lo_n;
  logic        oe_n, gw_n, bwe_n, sleep;
  logic [1:0]  bw_n;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic        rd_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [17:0] ref_m [256];

  always #5 clk = ~clk;

  fts_burst_ram dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cpu_stb_n(cpu_stb_n),
    .ctl_stb_n(ctl_stb_n), .adv_n(adv_n), .order_il(order_il), .ce_n(ce_n),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .oe_n(oe_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .sleep(sleep), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  function automatic logic [17:0] pat(input int a, input int s);
    return 18'((a * 37 + s * 1013) ^ 18'h2A5A5);
  endfunction

  task automatic chk(input logic [17:0] act, input logic [17:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_stb_n = 1; ctl_stb_n = 1; adv_n = 1; ce_n = 0; cs_hi = 1; cs_lo_n = 0;
    oe_n = 0; gw_n = 1; bwe_n = 1; bw_n = 2'b11; sleep = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ctl_write(input logic [7:0] a, input logic [17:0] d);
    addr_i = a; ctl_stb_n = 0; gw_n = 0; wdata = d;
    cyc(); idle();
    ref_m[a] = d;
  endtask

  task automatic cpu_load(input logic [7:0] a);
    addr_i = a; cpu_stb_n = 0;
    cyc(); cpu_stb_n = 1; #1;
  endtask

  task automatic read_burst(input logic [7:0] a, input logic il, input int len, input string tag);
    order_il = il;
    cpu_load(a);
    for (int k = 0; k < len; k++) begin
      logic [1:0] lo;
      logic [7:0] e;
      if (k > 0) begin adv_n = 0; cyc(); adv_n = 1; #1; end
      lo = il ? (a[1:0] ^ 2'(k)) : (a[1:0] + 2'(k));
      e = {a[7:2], lo};
      chk(rdata, ref_m[e], tag);
      chk({17'd0, rd_valid}, 18'd1, tag);
    end
    order_il = 0;
  endtask

  task automatic t_reset();
    chk({17'd0, rd_valid}, 18'd0, "R11 valid after reset");
    chk(rdata, 18'd0, "R11 data after reset");
  endtask

  task automatic t_orders();
    for (int i = 0; i < 4; i++) ctl_write(8'h10 + 8'(i), pat(16 + i, 1));
    read_burst(8'h11, 0, 5, "R4 R2 linear from 1 with wrap");
    read_burst(8'h12, 1, 4, "R5 interleaved from 2");
    read_burst(8'h11, 1, 4, "R5 interleaved from 1");
    read_burst(8'h13, 0, 4, "R4 linear from 3");
  endtask

  task automatic t_hold_oe();
    cpu_load(8'h10);
    cyc(); cyc();
    chk(rdata, ref_m[8'h10], "R3 hold without advance");
    oe_n = 1; #1;
    chk({17'd0, rd_valid}, 18'd0, "R2 valid with oe high");
    chk(rdata, 18'd0, "R2 data with oe high");
    oe_n = 0; #1;
    chk(rdata, ref_m[8'h10], "R2 data with oe low again");
  endtask

  task automatic t_bytes();
    logic [17:0] x, y, z, w;
    for (int i = 0; i < 4; i++) ctl_write(8'h20 + 8'(i), pat(32 + i, 2));
    x = pat(1, 7); y = pat(2, 7); z = pat(3, 7); w = pat(4, 7);
    cpu_load(8'h20);
    bwe_n = 0; bw_n = 2'b10; wdata = x; adv_n = 0; cyc();
    ref_m[8'h20][8:0] = x[8:0];
    bw_n = 2'b01; wdata = y; cyc();
    ref_m[8'h21][17:9] = y[17:9];
    bwe_n = 1; bw_n = 2'b00; gw_n = 1; wdata = z; cyc();
    gw_n = 0; bwe_n = 0; bw_n = 2'b11; wdata = w; adv_n = 1; cyc();
    ref_m[8'h23] = w;
    idle(); #1;
    chk(rdata, w, "R8 R6 burst write visible next cycle");
    read_burst(8'h20, 0, 4, "R7 R8 lane writes during burst");
  endtask

  task automatic t_priority();
    cpu_load(8'h13);
    addr_i = 8'h10; cpu_stb_n = 0; ctl_stb_n = 0; gw_n = 0; wdata = pat(9, 9);
    cyc(); idle(); #1;
    chk(rdata, ref_m[8'h10], "R1 cpu strobe wins, no write");
    chk({17'd0, rd_valid}, 18'd1, "R1 loaded valid");
    ctl_write(8'h30, pat(48, 3));
    cpu_load(8'h10);
    ce_n = 1; cpu_stb_n = 0; addr_i = 8'h30; cyc();
    ce_n = 0; cpu_stb_n = 1; #1;
    chk(rdata, ref_m[8'h10], "R1 cpu strobe ignored with ce high");
    chk({17'd0, rd_valid}, 18'd1, "R1 burst kept");
  endtask

  task automatic t_deselect();
    cpu_load(8'h10);
    addr_i = 8'h11; ctl_stb_n = 0; cs_hi = 0; cyc(); idle(); #1;
    chk({17'd0, rd_valid}, 18'd0, "R9 deselect by cs_hi");
    cpu_load(8'h10);
    addr_i = 8'h11; ctl_stb_n = 0; ce_n = 1; cyc(); idle(); #1;
    chk({17'd0, rd_valid}, 18'd0, "R9 deselect by ce_n");
    cpu_load(8'h10);
    addr_i = 8'h11; cpu_stb_n = 0; cs_lo_n = 1; cyc(); idle(); #1;
    chk({17'd0, rd_valid}, 18'd0, "R9 deselect by cs_lo_n");
    adv_n = 0; cyc(); adv_n = 1; #1;
    chk({17'd0, rd_valid}, 18'd0, "R9 advance stays deselected");
  endtask

  task automatic t_sleep();
    cpu_load(8'h11);
    sleep = 1; #1;
    chk({17'd0, rd_valid}, 18'd0, "R10 valid during sleep");
    chk(rdata, 18'd0, "R10 data during sleep");
    adv_n = 0; gw_n = 0; wdata = pat(5, 5); ctl_stb_n = 0; addr_i = 8'h12;
    cyc(); cyc();
    idle(); #1;
    chk(rdata, ref_m[8'h11], "R10 state and memory frozen");
    adv_n = 0; cyc(); adv_n = 1; #1;
    chk(rdata, ref_m[8'h12], "R10 burst resumes");
  endtask

  initial begin
    idle(); order_il = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    cyc();
    t_reset();
    t_orders();
    t_hold_oe();
    t_bytes();
    t_priority();
    t_deselect();
    t_sleep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule